// File: doc/BRIEF.md
# Unique Access History Recorder

This block watches the stream of demand data accesses leaving a core and keeps a record of which cache lines were touched. Every access is reduced to its 64-byte line number. That number is logged in two places. One is a single global history that keeps lines in arrival order. The other is a set of short histories, each owned by one load or store instruction and selected by the instruction's program counter. A line is logged in a history only the first time it appears there, so a loop that hammers one line does not flush the record of more distant lines. Each logged entry also carries whether the access missed in the cache, so a later stage can study the full access stream or the miss stream alone.

The per-instruction histories live in a fixed number of rows. Each row has a program-counter tag. When an instruction is seen whose counter owns no row, the least recently used row is taken over: its tag is rewritten and its old entries are discarded. A read port lets a downstream pattern detector fetch any entry of the global history, or of the row that belongs to a given counter. Entries are numbered from the oldest, and each comes with a valid flag. The detector walks an index to obtain an ordered snapshot. The recorder itself does no pattern analysis and issues no prefetches.

Top module: `hist_recorder`

## Requirements
- R1: The logged line number is the byte address with its low 6 bits dropped, i.e. address bits [31:6], 26 bits wide.
- R2: The global history holds 128 entries numbered 0 (oldest) upward. A new unique line goes to the end. When all 128 are in use, entry 0 is discarded and the others move down by one.
- R3: An access whose line is already present in the global history is not logged there again, and the existing entry keeps both its position and its info bits.
- R4: An access whose program counter matches a row's tag is appended to that row, unless the line is already present in that row. Duplicates leave the row's order unchanged.
- R5: An access whose counter matches no row takes over the least recently used row. That row is cleared and retagged, and it then holds only the new line. Any access promotes its row to most recently used. After reset, rows are taken over in index order.
- R6: Each row holds 24 entries. When a full row receives a new unique line, its oldest entry is discarded.
- R7: Each entry's 2-bit info field has bit 0 equal to 1 for a miss and 0 for a hit. Bit 1 is always 0.
- R8: A read request (rd_en high at a clock edge) is answered at the next edge. rd_ack goes high with the entry at rd_idx, counted from the oldest. The entry comes from the global history when rd_local is 0, or from the row tagged rd_pc when rd_local is 1. rd_row_hit reports whether such a row exists and is 0 for global reads. rd_vld is 0, with rd_line and rd_info 0, when the index is past the filled entries or no row matches.
- R9: An access in the same cycle as a read request does not affect that read's answer. It is visible to reads issued in later cycles.
- R10: Synchronous active-low reset empties the global history and invalidates every row tag, and it clears all read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Virtual byte address of the access |
| acc_pc | input | 32 | Program counter of the accessing instruction |
| acc_miss | input | 1 | 1 when the access missed in the cache |
| rd_en | input | 1 | Read request |
| rd_local | input | 1 | 0 selects the global history, 1 selects a per-instruction row |
| rd_pc | input | 32 | Program counter selecting the row for a local read |
| rd_idx | input | 7 | Entry index, 0 is the oldest |
| rd_ack | output | 1 | Read answer is present |
| rd_vld | output | 1 | Addressed entry exists |
| rd_row_hit | output | 1 | A row tagged rd_pc exists (local reads) |
| rd_line | output | 26 | Line number of the entry |
| rd_info | output | 2 | Info field of the entry |

## Verification
The recorder is driven with a unit-stride line stream that uses varied byte offsets and alternating hit and miss flags. This separates correct line extraction and info encoding from ordering faults. It then revisits an already logged line with a different offset and miss flag, which shows whether duplicates are dropped or overwrite the older entry. A single instruction is given more lines than a row holds, and a long unique stream is given to the global history, so that displacement of the oldest entry is checked at both capacities. Finally, every row is filled with distinct counters while one early counter is re-touched. New counters then expose whether takeover follows recency or plain index order, and whether a taken-over row really starts empty. A read issued in the same cycle as an access checks that the answer reflects the state before that access.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int INFO_W = 2;

  // Info field: bit0 = miss flag, bit1 reserved zero.
  function automatic logic [INFO_W-1:0] make_info(input logic miss);
    return {1'b0, miss};
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hist_ring.sv
module hist_ring #(
  parameter int DEPTH  = 128,
  parameter int LINE_W = 26,
  parameter int RIDX_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [LINE_W-1:0]           in_line,
  input  logic [hist_pkg::INFO_W-1:0] in_info,
  output logic                        dup,
  output logic [$clog2(DEPTH+1)-1:0]  cnt,
  input  logic [RIDX_W-1:0]           rd_idx,
  output logic                        rd_ok,
  output logic [LINE_W-1:0]           rd_line,
  output logic [hist_pkg::INFO_W-1:0] rd_info
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [LINE_W-1:0]           lines [DEPTH];
  logic [hist_pkg::INFO_W-1:0] infos [DEPTH];
  logic                        full;

  assign full = (cnt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= push ? CW'(1) : '0;
      if (push) begin
        lines[0] <= in_line;
        infos[0] <= in_info;
      end
    end else if (push) begin
      if (!full) begin
        lines[cnt[IW-1:0]] <= in_line;
        infos[cnt[IW-1:0]] <= in_info;
        cnt <= cnt + 1'b1;
      end else begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          lines[i] <= lines[i+1];
          infos[i] <= infos[i+1];
        end
        lines[DEPTH-1] <= in_line;
        infos[DEPTH-1] <= in_info;
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt && lines[i] == in_line) dup = 1'b1;
  end

  always_comb begin
    rd_ok   = int'(rd_idx) < int'(cnt);
    rd_line = '0;
    rd_info = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_ok && int'(rd_idx) == i) begin
        rd_line = lines[i];
        rd_info = infos[i];
      end
  end

  AST_RING_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr && !full |=> cnt == $past(cnt) + 1'b1); // R2
  AST_RING_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R6
  AST_RING_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr && full |=> full); // R6
  AST_RING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !push |=> cnt == '0); // R5
endmodule

// File: rtl/hist_lru.sv
module hist_lru #(
  parameter int ROWS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch,
  input  logic [$clog2(ROWS)-1:0] touch_row,
  output logic [$clog2(ROWS)-1:0] victim
);
  localparam int RW = $clog2(ROWS);

  // rank 0 = least recent, ROWS-1 = most recent
  logic [RW-1:0]   rank [ROWS];
  logic [ROWS-1:0] at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rank[r] <= RW'(r);
    end else if (touch) begin
      for (int r = 0; r < ROWS; r++) begin
        if (RW'(r) == touch_row)            rank[r] <= RW'(ROWS - 1);
        else if (rank[r] > rank[touch_row]) rank[r] <= rank[r] - 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      at_zero[r] = (rank[r] == '0);
      if (at_zero[r]) victim = RW'(r);
    end
  end

  AST_LRU_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(at_zero) == 1); // R5
  AST_LRU_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> rank[$past(touch_row)] == RW'(ROWS - 1)); // R5
endmodule

// File: rtl/hist_tags.sv
module hist_tags #(
  parameter int ROWS = 32,
  parameter int PC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [$clog2(ROWS)-1:0] wr_row,
  input  logic [PC_W-1:0]         wr_pc,
  input  logic [PC_W-1:0]         pc_a,
  output logic                    hit_a,
  output logic [$clog2(ROWS)-1:0] row_a,
  input  logic [PC_W-1:0]         pc_b,
  output logic                    hit_b,
  output logic [$clog2(ROWS)-1:0] row_b
);
  localparam int RW = $clog2(ROWS);

  logic [PC_W-1:0] tag [ROWS];
  logic [ROWS-1:0] tval;
  logic [ROWS-1:0] match_a, match_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tval <= '0;
    end else if (wr) begin
      tag[wr_row]  <= wr_pc;
      tval[wr_row] <= 1'b1;
    end
  end

  always_comb begin
    row_a = '0;
    row_b = '0;
    for (int r = 0; r < ROWS; r++) begin
      match_a[r] = tval[r] && (tag[r] == pc_a);
      match_b[r] = tval[r] && (tag[r] == pc_b);
      if (match_a[r]) row_a = RW'(r);
      if (match_b[r]) row_b = RW'(r);
    end
    hit_a = |match_a;
    hit_b = |match_b;
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_a)); // R4
  AST_TAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && pc_a == wr_pc |=> hit_a || pc_a != $past(wr_pc)); // R5
endmodule

// File: rtl/hist_recorder.sv
module hist_recorder #(
  parameter int ADDR_W   = 32,
  parameter int PC_W     = 32,
  parameter int LINE_OFS = 6,
  parameter int LINE_W   = 26,
  parameter int G_DEPTH  = 128,
  parameter int L_ROWS   = 32,
  parameter int L_DEPTH  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic              acc_miss,
  input  logic              rd_en,
  input  logic              rd_local,
  input  logic [PC_W-1:0]   rd_pc,
  input  logic [$clog2(hist_pkg::max_int(G_DEPTH, L_DEPTH))-1:0] rd_idx,
  output logic              rd_ack,
  output logic              rd_vld,
  output logic              rd_row_hit,
  output logic [LINE_W-1:0] rd_line,
  output logic [hist_pkg::INFO_W-1:0] rd_info
);
  import hist_pkg::*;

  localparam int RIDX_W = $clog2(max_int(G_DEPTH, L_DEPTH));
  localparam int RW     = $clog2(L_ROWS);
  localparam int GCW    = $clog2(G_DEPTH + 1);
  localparam int LCW    = $clog2(L_DEPTH + 1);

  // Access decode
  logic [LINE_W-1:0] acc_line;
  logic [INFO_W-1:0] acc_info;
  logic              unused_low_bits;

  assign acc_line        = acc_addr[LINE_OFS +: LINE_W];
  assign acc_info        = make_info(acc_miss);
  assign unused_low_bits = ^acc_addr[LINE_OFS-1:0];

  // Row selection
  logic          a_hit, b_hit;
  logic [RW-1:0] a_row, b_row, victim, tgt_row;
  logic          l_alloc;

  assign l_alloc = acc_valid && !a_hit;
  assign tgt_row = a_hit ? a_row : victim;

  hist_tags #(.ROWS(L_ROWS), .PC_W(PC_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .wr(l_alloc), .wr_row(victim), .wr_pc(acc_pc),
    .pc_a(acc_pc), .hit_a(a_hit), .row_a(a_row),
    .pc_b(rd_pc), .hit_b(b_hit), .row_b(b_row)
  );

  hist_lru #(.ROWS(L_ROWS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch(acc_valid), .touch_row(tgt_row), .victim(victim)
  );

  // Global history
  logic              g_dup, g_append, g_rok;
  logic [GCW-1:0]    g_cnt;
  logic [LINE_W-1:0] g_rline;
  logic [INFO_W-1:0] g_rinfo;

  assign g_append = acc_valid && !g_dup;

  hist_ring #(.DEPTH(G_DEPTH), .LINE_W(LINE_W), .RIDX_W(RIDX_W)) u_global (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .push(g_append),
    .in_line(acc_line), .in_info(acc_info), .dup(g_dup), .cnt(g_cnt),
    .rd_idx(rd_idx), .rd_ok(g_rok), .rd_line(g_rline), .rd_info(g_rinfo)
  );

  // Local histories
  logic [L_ROWS-1:0] l_dup, l_push, l_clr, l_rok;
  logic [LINE_W-1:0] l_rline [L_ROWS];
  logic [INFO_W-1:0] l_rinfo [L_ROWS];
  logic [LCW-1:0]    l_cnt   [L_ROWS];

  for (genvar r = 0; r < L_ROWS; r++) begin : g_row
    logic row_sel;
    assign row_sel  = acc_valid && (tgt_row == RW'(r));
    assign l_clr[r] = l_alloc && (victim == RW'(r));
    assign l_push[r] = row_sel && (l_clr[r] || !l_dup[r]);

    hist_ring #(.DEPTH(L_DEPTH), .LINE_W(LINE_W), .RIDX_W(RIDX_W)) u_row (
      .clk(clk), .rst_n(rst_n), .clr(l_clr[r]), .push(l_push[r]),
      .in_line(acc_line), .in_info(acc_info), .dup(l_dup[r]), .cnt(l_cnt[r]),
      .rd_idx(rd_idx), .rd_ok(l_rok[r]), .rd_line(l_rline[r]), .rd_info(l_rinfo[r])
    );

    AST_ROW_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      l_clr[r] |=> l_cnt[r] == LCW'(1)); // R5
  end

  // Read port: registered, sees pre-access state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack     <= 1'b0;
      rd_vld     <= 1'b0;
      rd_row_hit <= 1'b0;
      rd_line    <= '0;
      rd_info    <= '0;
    end else begin
      rd_ack <= rd_en;
      if (rd_en) begin
        if (!rd_local) begin
          rd_row_hit <= 1'b0;
          rd_vld     <= g_rok;
          rd_line    <= g_rok ? g_rline : '0;
          rd_info    <= g_rok ? g_rinfo : '0;
        end else begin
          rd_row_hit <= b_hit;
          rd_vld     <= b_hit && l_rok[b_row];
          rd_line    <= (b_hit && l_rok[b_row]) ? l_rline[b_row] : '0;
          rd_info    <= (b_hit && l_rok[b_row]) ? l_rinfo[b_row] : '0;
        end
      end
    end
  end

  AST_GLOBAL_NO_RELOG: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && g_dup |=> g_cnt == $past(g_cnt)); // R3
  AST_ONE_ROW_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_push)); // R4
  AST_READ_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_ack); // R8
  AST_NO_ROW_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !rd_row_hit && $past(rd_local) |-> !rd_vld); // R8
  AST_INFO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !rd_info[1]); // R7
endmodule

// File: tb/sim_hist_recorder.sv
module sim_hist_recorder;
  localparam int CLK_PERIOD = 10;
  localparam int GD = 128;
  localparam int LR = 32;
  localparam int LD = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_miss = 1'b0;
  logic [31:0] acc_addr = '0, acc_pc = '0;
  logic        rd_en = 1'b0, rd_local = 1'b0;
  logic [31:0] rd_pc = '0;
  logic [6:0]  rd_idx = '0;
  logic        rd_ack, rd_vld, rd_row_hit;
  logic [25:0] rd_line;
  logic [1:0]  rd_info;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_recorder u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_pc(acc_pc), .acc_miss(acc_miss), .rd_en(rd_en), .rd_local(rd_local),
    .rd_pc(rd_pc), .rd_idx(rd_idx), .rd_ack(rd_ack), .rd_vld(rd_vld),
    .rd_row_hit(rd_row_hit), .rd_line(rd_line), .rd_info(rd_info)
  );

  // Reference model: entries are {miss, line}
  logic [26:0] gq[$];
  logic [26:0] lq[LR][$];
  logic [31:0] ltag[LR];
  bit          lval[LR];
  int          lru[$];

  // Scoreboard: {vld, row_hit, line, info}
  logic [29:0] exp_q[$];
  string       tag_q[$];

  function automatic int find_row(input logic [31:0] pc);
    for (int r = 0; r < LR; r++) if (lval[r] && ltag[r] == pc) return r;
    return -1;
  endfunction

  function automatic bit in_q(ref logic [26:0] q[$], input logic [25:0] ln);
    foreach (q[i]) if (q[i][25:0] == ln) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_access(input logic [31:0] addr, input logic [31:0] pc, input bit miss);
    logic [25:0] ln = addr >> 6;
    int r;
    if (!in_q(gq, ln)) begin
      gq.push_back({miss, ln});
      if (gq.size() > GD) void'(gq.pop_front());
    end
    r = find_row(pc);
    if (r < 0) begin
      r = lru[0];
      ltag[r] = pc;
      lval[r] = 1'b1;
      lq[r].delete();
    end
    if (!in_q(lq[r], ln)) begin
      lq[r].push_back({miss, ln});
      if (lq[r].size() > LD) void'(lq[r].pop_front());
    end
    foreach (lru[i]) if (lru[i] == r) begin lru.delete(i); break; end
    lru.push_back(r);
  endtask

  function automatic logic [29:0] model_read(input bit loc, input logic [31:0] pc, input int idx);
    logic [26:0] e;
    int r;
    if (!loc) begin
      if (idx < gq.size()) begin e = gq[idx]; return {1'b1, 1'b0, e[25:0], 1'b0, e[26]}; end
      return '0;
    end
    r = find_row(pc);
    if (r < 0) return '0;
    if (idx < lq[r].size()) begin e = lq[r][idx]; return {1'b1, 1'b1, e[25:0], 1'b0, e[26]}; end
    return {1'b0, 1'b1, 26'd0, 2'd0};
  endfunction

  // Driver: one cycle, optional access and optional read
  task automatic step(input bit av, input logic [31:0] addr, input logic [31:0] pc, input bit miss,
                      input bit rv, input bit loc, input logic [31:0] rpc, input int idx,
                      input string tag);
    @(negedge clk);
    if (rv) begin
      exp_q.push_back(model_read(loc, rpc, idx)); // R9: expected taken before the access
      tag_q.push_back(tag);
    end
    if (av) model_access(addr, pc, miss);
    acc_valid = av; acc_addr = addr; acc_pc = pc; acc_miss = miss;
    rd_en = rv; rd_local = loc; rd_pc = rpc; rd_idx = 7'(idx);
  endtask

  task automatic acc(input logic [31:0] line, input logic [5:0] ofs, input logic [31:0] pc, input bit miss);
    step(1'b1, (line << 6) | 32'(ofs), pc, miss, 1'b0, 1'b0, 0, 0, "");
  endtask

  task automatic rd(input bit loc, input logic [31:0] pc, input int idx, input string tag);
    step(1'b0, 0, 0, 1'b0, 1'b1, loc, pc, idx, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, "");
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      logic [29:0] got, exp;
      string t;
      got = {rd_vld, rd_row_hit, rd_line, rd_info};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected answer got=%h expected none", got);
      end else begin
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s: got vld=%0b hit=%0b line=%h info=%0d expected vld=%0b hit=%0b line=%h info=%0d",
                   t, got[29], got[28], got[27:2], got[1:0], exp[29], exp[28], exp[27:2], exp[1:0]);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no end expected end of run");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] PC_A = 32'h0040_1000;
  localparam logic [31:0] PC_B = 32'h0040_2000;
  localparam logic [31:0] PC_D = 32'h0040_9000;
  localparam logic [31:0] PC_E = 32'h0040_A000;
  localparam logic [31:0] PC_F = 32'h0040_B000;

  initial begin
    for (int r = 0; r < LR; r++) begin lru.push_back(r); lval[r] = 1'b0; end
    repeat (3) @(negedge clk);
    // R10: outputs cleared during reset
    checks++;
    if ({rd_ack, rd_vld, rd_row_hit, rd_line, rd_info} !== '0) begin
      errors++;
      $display("FAIL R10: got outputs=%h expected 0", {rd_ack, rd_vld, rd_row_hit, rd_line, rd_info});
    end
    rst_n = 1'b1;
    rd(1'b0, 0, 0, "R10 global empty");
    rd(1'b1, PC_A, 0, "R10 no row tags");

    // R1 R7 R2 R4: unit stride with varied offsets and alternating miss
    for (int i = 0; i < 5; i++) acc(32'h0100 + i, 6'(7 * i + 3), PC_A, i[0]);
    for (int i = 0; i < 6; i++) rd(1'b0, 0, i, "R1 R2 R7 global stride");
    for (int i = 0; i < 6; i++) rd(1'b1, PC_A, i, "R4 local stride");

    // R3 R4: revisit line 0x102 with other offset and miss flag
    acc(32'h0102, 6'h3f, PC_A, 1'b1);
    rd(1'b0, 0, 2, "R3 entry unchanged");
    rd(1'b0, 0, 5, "R3 not relogged");
    rd(1'b1, PC_A, 5, "R4 local duplicate dropped");

    // R9: read and access in the same cycle
    step(1'b1, 32'h0200 << 6, PC_A, 1'b1, 1'b1, 1'b0, 0, 5, "R9 same cycle read");
    rd(1'b0, 0, 5, "R9 visible afterwards");

    // R6: one instruction exceeds row capacity
    for (int i = 0; i < 26; i++) acc(32'h0300 + i, 6'h0, PC_B, 1'b0);
    rd(1'b1, PC_B, 0, "R6 oldest displaced");
    rd(1'b1, PC_B, 23, "R6 newest at end");
    rd(1'b1, PC_B, 24, "R6 beyond capacity");

    // R5: fill the remaining rows, re-touch A, then new counters reclaim LRU
    for (int i = 0; i < 30; i++) acc(32'h0500 + i, 6'h0, 32'h0070_0000 + 32'(i * 4), 1'b0);
    acc(32'h0101, 6'h1, PC_A, 1'b0);
    acc(32'h0600, 6'h0, PC_D, 1'b1);
    rd(1'b1, PC_B, 0, "R5 LRU row reclaimed");
    rd(1'b1, PC_A, 0, "R5 promoted row kept");
    rd(1'b1, PC_D, 0, "R5 new row first entry");
    rd(1'b1, PC_D, 1, "R5 new row starts empty");
    acc(32'h0601, 6'h0, PC_E, 1'b0);
    rd(1'b1, 32'h0070_0000, 0, "R5 next LRU reclaimed");
    rd(1'b1, 32'h0070_0004, 0, "R5 other row kept");

    // R2: global overflow
    for (int i = 0; i < 140; i++) acc(32'h1000 + i, 6'h2, PC_F, i[1]);
    rd(1'b0, 0, 0, "R2 oldest after overflow");
    rd(1'b0, 0, 127, "R2 newest after overflow");
    rd(1'b1, PC_F, 0, "R6 row after long stream");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: got %0d unanswered reads expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule